// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Commit

This block sits behind the serial command decoder of a small nonvolatile memory. For an array write it gathers the incoming data bytes into a page-sized staging buffer. The slot pointer starts at the low bits of the start address and wraps within the page, so a long burst overwrites the slots it filled earlier. When chip-select rises, the block decides from the raw bit count whether the session ended cleanly on a byte boundary. If it did, a self-timed programming period begins, and the buffered bytes are copied into the array one slot per clock. A status-register write uses the same commit decision, but with an exact 16-clock total, and it emits a single status write.

The decoder opens a session with `start_valid` and says whether it targets the array or the status register. Data bytes arrive on a valid/ready stream. `byte_ready` is high for the whole of an open session and low at every other time. A byte moves on a clock edge where `byte_valid` and `byte_ready` are both high. When ready is low the byte is not taken, and the source may drop it or hold it. Back-pressure therefore only ever means that no session is open or that programming is under way. `done` tells the surrounding logic to clear its write-enable latch.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, `busy`, `done`, `arr_we`, `sts_we` and `byte_ready` are all low.
- R2: Accepted array bytes fill slots starting at slot `start_addr[3:0]`, incrementing by one per byte. In busy cycle k (k = 0 for the first busy cycle), slot k is written if it holds a byte: `arr_addr` = {`start_addr[8:4]`, k} and `arr_wdata` = that byte.
- R3: After slot 15 the next byte goes to slot 0 of the same page. A later byte replaces an earlier byte in the same slot.
- R4: Only slots that received a byte in the session are written. Slots that received no byte produce no `arr_we`.
- R5: An array write commits only if, at the `cs_rise` pulse, `cs_bits` is a multiple of 8 and at least 24. Otherwise no write is made, `busy` stays low and the session closes.
- R6: A status write commits only if `cs_bits` equals exactly 16 at `cs_rise`. It then raises `sts_we` for the first busy cycle only, with `sts_wdata` equal to the first byte of the session, and makes no array write.
- R7: If `wr_permit` is low in any cycle from the cycle that opens the session up to and including the `cs_rise` cycle, the write is cancelled.
- R8: `busy` rises in the cycle after a committing `cs_rise` and stays high for exactly `PROG_TICKS` cycles.
- R9: `done` is a single-cycle pulse in the first cycle after the last busy cycle.
- R10: While `busy` is high, `byte_ready` is low, and `start_valid`, `byte_valid` and `cs_rise` have no effect. The running cycle's writes, length and single `done` are unchanged, and no second cycle follows.
- R11: `byte_ready` rises in the cycle after `start_valid` is accepted and falls in the cycle after the closing `cs_rise`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Opens a write session (pulse) |
| start_is_status | input | 1 | 1: status-register write, 0: array write |
| start_addr | input | ADDR_W | Start byte address of an array write |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Data byte can be taken |
| byte_data | input | DATA_W | Data byte |
| cs_rise | input | 1 | Chip-select has risen (pulse) |
| cs_bits | input | CNT_W | Bits clocked in since select, counted at the rise |
| wr_permit | input | 1 | Write enable latch set and protect pin inactive |
| busy | output | 1 | Programming period in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| sts_we | output | 1 | Status-register write strobe |
| sts_wdata | output | DATA_W | Status-register write data |
| done | output | 1 | Programming finished, clear the write-enable latch |

## Verification
The hardest situation to reach is traffic that arrives while the programming period is running. It has to be shown that a fresh start, an offered byte and a well-formed 24-bit chip-select rise, all landing mid-cycle, change neither the write sequence nor the cycle length, and that no second cycle follows. The stimulus commits a random page write, waits a few busy cycles, and then fires all three inputs together. The random part also draws bursts longer than a page, so wrap and overwrite occur often, and it draws bit counts a few bits off a byte boundary, so commits and cancels are mixed.

// File: rtl/pcw_pkg.sv
`timescale 1ns/1ps
package pcw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARR  = 2'd1,
    ST_STS  = 2'd2,
    ST_PROG = 2'd3
  } pcw_state_e;

  // instruction plus address occupy two bytes before data
  localparam int unsigned HDR_BYTES = 2;
endpackage

// File: rtl/pcw_page_buffer.sv
`timescale 1ns/1ps
module pcw_page_buffer #(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned SW        = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [SW-1:0]         base_slot,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [SW-1:0]         rd_slot,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PAGE_BYTES-1:0] valid_mask
);
  logic [SW-1:0]     ptr_q;
  logic [DATA_W-1:0] slot_q [PAGE_BYTES];

  // pointer wraps naturally within the power-of-two page
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (clr)   ptr_q <= base_slot;
    else if (wr_en) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (ptr_q == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_mask[g] <= 1'b0;
      else if (clr) valid_mask[g] <= 1'b0;
      else if (hit) valid_mask[g] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_slot];
endmodule

// File: rtl/pcw_prog_timer.sv
`timescale 1ns/1ps
module pcw_prog_timer #(
  parameter int unsigned TICKS = 2_500_000,
  localparam int unsigned TW   = $clog2(TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  output logic          busy,
  output logic [TW-1:0] idx,
  output logic          last,
  output logic          done
);
  assign last = busy && (idx == TW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (last) begin
          busy <= 1'b0;
          idx  <= '0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (kick) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end
  end
endmodule

// File: rtl/pcw_commit_check.sv
`timescale 1ns/1ps
module pcw_commit_check #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic             is_status,
  input  logic             permit_ok,
  input  logic [CNT_W-1:0] bits,
  output logic             go
);
  import pcw_pkg::*;
  localparam int unsigned HDR_BITS = HDR_BYTES * DATA_W;

  logic on_byte, array_ok, status_ok;

  always_comb begin
    on_byte   = (bits % CNT_W'(DATA_W)) == '0;
    array_ok  = on_byte && (bits >= CNT_W'(HDR_BITS + DATA_W));
    status_ok = (bits == CNT_W'(HDR_BITS));
    go        = permit_ok && (is_status ? status_ok : array_ok);
  end
endmodule

// File: rtl/page_commit_engine.sv
`timescale 1ns/1ps
module page_commit_engine #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PROG_TICKS = 2_500_000,
  localparam int unsigned SW        = $clog2(PAGE_BYTES),
  localparam int unsigned TW        = $clog2(PROG_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic              start_is_status,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic [CNT_W-1:0]  cs_bits,
  input  logic              wr_permit,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              sts_we,
  output logic [DATA_W-1:0] sts_wdata,
  output logic              done
);
  import pcw_pkg::*;

  pcw_state_e           st_q;
  logic [ADDR_W-SW-1:0] page_q;
  logic                 perm_q;
  logic                 prog_sts_q;
  logic [DATA_W-1:0]    sts_q;
  logic                 sts_got_q;

  logic                  in_session, take, arr_take, open_req;
  logic                  go, kick;
  logic                  t_last;
  logic [TW-1:0]         t_idx;
  logic [SW-1:0]         wb_slot;
  logic                  in_window;
  logic [DATA_W-1:0]     buf_rd;
  logic [PAGE_BYTES-1:0] buf_mask;

  assign in_session = (st_q == ST_ARR) || (st_q == ST_STS);
  assign byte_ready = in_session;
  assign take       = byte_valid && byte_ready;
  assign arr_take   = take && (st_q == ST_ARR);
  assign open_req   = start_valid && (st_q == ST_IDLE);

  pcw_commit_check #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_check (
    .is_status (st_q == ST_STS),
    .permit_ok (perm_q && wr_permit),
    .bits      (cs_bits),
    .go        (go)
  );

  assign kick = in_session && cs_rise && go;

  pcw_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (open_req && !start_is_status),
    .base_slot  (start_addr[SW-1:0]),
    .wr_en      (arr_take),
    .wr_data    (byte_data),
    .rd_slot    (wb_slot),
    .rd_data    (buf_rd),
    .valid_mask (buf_mask)
  );

  pcw_prog_timer #(.TICKS(PROG_TICKS)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .kick (kick),
    .busy (busy),
    .idx  (t_idx),
    .last (t_last),
    .done (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      page_q     <= '0;
      perm_q     <= 1'b0;
      prog_sts_q <= 1'b0;
      sts_q      <= '0;
      sts_got_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_valid) begin
            st_q      <= start_is_status ? ST_STS : ST_ARR;
            page_q    <= start_addr[ADDR_W-1:SW];
            perm_q    <= wr_permit;
            sts_got_q <= 1'b0;
          end
        end
        ST_ARR, ST_STS: begin
          perm_q <= perm_q && wr_permit;
          if (st_q == ST_STS && take && !sts_got_q) begin
            sts_q     <= byte_data;
            sts_got_q <= 1'b1;
          end
          if (cs_rise) begin
            st_q       <= go ? ST_PROG : ST_IDLE;
            prog_sts_q <= (st_q == ST_STS);
          end
        end
        ST_PROG: begin
          if (t_last) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // write-back walk: busy cycle k services slot k
  assign wb_slot   = t_idx[SW-1:0];
  assign in_window = t_idx < TW'(PAGE_BYTES);
  assign arr_we    = busy && !prog_sts_q && in_window && buf_mask[wb_slot];
  assign arr_addr  = {page_q, wb_slot};
  assign arr_wdata = buf_rd;
  assign sts_we    = busy && prog_sts_q && (t_idx == '0);
  assign sts_wdata = sts_q;
endmodule

// File: rtl/pcw_checker.sv
`timescale 1ns/1ps
module pcw_checker #(
  parameter int unsigned PROG_TICKS = 2_500_000
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic byte_ready,
  input logic arr_we,
  input logic sts_we,
  input logic cs_rise
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  a_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 32'(PROG_TICKS)));

  a_r8_busy_from_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready);

  a_r2_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  a_r6_sts_excl: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |-> (busy && !arr_we));
endmodule

bind page_commit_engine pcw_checker #(.PROG_TICKS(PROG_TICKS)) u_pcw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .byte_ready (byte_ready),
  .arr_we     (arr_we),
  .sts_we     (sts_we),
  .cs_rise    (cs_rise)
);

// File: tb/page_commit_engine_bench.sv
`timescale 1ns/1ps
module page_commit_engine_bench;
  localparam int AW = 9;
  localparam int CW = 16;
  localparam int PT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 0, start_is_status = 0, byte_valid = 0, cs_rise = 0, wr_permit = 1;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic [CW-1:0] cs_bits = '0;
  logic byte_ready, busy, arr_we, sts_we, done;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, sts_wdata;

  always #2 clk = ~clk;

  page_commit_engine #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(16), .CNT_W(CW), .PROG_TICKS(PT))
  u_page_commit_engine (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_is_status(start_is_status),
    .start_addr(start_addr), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .cs_rise(cs_rise), .cs_bits(cs_bits), .wr_permit(wr_permit),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .done(done)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor, sampling 1 ns after each rising edge
  int mon_t = 0, busy_n = 0, first_busy = -1, done_n = 0, done_t = -1;
  int sts_n = 0, sts_t = -1, stray = 0;
  bit mon_on = 0;
  logic last_busy = 0;
  logic [7:0] sts_d = '0;
  bit got_we [16];
  int got_addr [16];
  int got_data [16];

  always @(posedge clk) begin
    #1;
    if (cs_rise && !last_busy) begin
      mon_on = 1; mon_t = 0; busy_n = 0; first_busy = -1; done_n = 0; done_t = -1;
      sts_n = 0; sts_t = -1; stray = 0;
      for (int i = 0; i < 16; i++) begin got_we[i] = 0; got_addr[i] = 0; got_data[i] = 0; end
    end else if (mon_on) mon_t++;
    if (mon_on) begin
      if (busy) begin busy_n++; if (first_busy < 0) first_busy = mon_t; end
      if (done) begin done_n++; done_t = mon_t; end
      if (arr_we) begin
        if (mon_t < 16 && !got_we[mon_t]) begin
          got_we[mon_t] = 1; got_addr[mon_t] = int'(arr_addr); got_data[mon_t] = int'(arr_wdata);
        end else stray++;
      end
      if (sts_we) begin sts_n++; sts_t = mon_t; sts_d = sts_wdata; end
    end
    last_busy = busy;
  end

  // expected-value functions
  function automatic bit exp_commit(int bits, bit is_sts, bit perm);
    if (!perm) return 0;
    if (is_sts) return bits == 16;
    return (bits % 8 == 0) && (bits >= 24);
  endfunction

  bit exp_v [16];
  int exp_d [16];

  task automatic open_session(logic [AW-1:0] a, bit sts);
    @(negedge clk);
    start_valid = 1; start_addr = a; start_is_status = sts;
    @(negedge clk);
    start_valid = 0;
  endtask

  task automatic send(logic [7:0] d);
    byte_valid = 1; byte_data = d;
    @(negedge clk);
    byte_valid = 0;
  endtask

  task automatic close(int bits);
    cs_rise = 1; cs_bits = CW'(bits);
    @(negedge clk);
    cs_rise = 0;
  endtask

  task automatic run_array(logic [AW-1:0] a, int n, int delta, bit drop_perm, bit inject, string tag);
    int ptr;
    bit c;
    for (int i = 0; i < 16; i++) begin exp_v[i] = 0; exp_d[i] = 0; end
    open_session(a, 0);
    chk("R11", {tag, " ready after open"}, byte_ready, 1);
    ptr = int'(a[3:0]);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom());
      exp_v[ptr] = 1; exp_d[ptr] = int'(d);
      send(d);
      if (drop_perm && i == n / 2) begin wr_permit = 0; @(negedge clk); wr_permit = 1; end
      ptr = (ptr + 1) % 16;
    end
    close(16 + 8 * n + delta);
    c = exp_commit(16 + 8 * n + delta, 0, !drop_perm);
    chk("R11", {tag, " ready after close"}, byte_ready, 0);
    if (inject && c) begin
      repeat (5) @(negedge clk);
      chk("R10", {tag, " ready while busy"}, byte_ready, 0);
      start_valid = 1; start_addr = ~a; start_is_status = 0;
      byte_valid = 1; byte_data = 8'h5A; cs_rise = 1; cs_bits = CW'(24);
      @(negedge clk);
      start_valid = 0; byte_valid = 0; cs_rise = 0;
    end
    repeat (PT + 6) @(negedge clk);
    if (c) begin
      chk("R8", {tag, " busy length"}, busy_n, PT);
      chk("R8", {tag, " busy start"}, first_busy, 0);
      chk("R9", {tag, " done count"}, done_n, 1);
      chk("R9", {tag, " done cycle"}, done_t, PT);
      for (int s = 0; s < 16; s++) begin
        chk("R4", {tag, " slot strobe"}, got_we[s], exp_v[s]);
        if (exp_v[s] && got_we[s]) begin
          chk("R2", {tag, " addr"}, got_addr[s], int'({a[AW-1:4], 4'(s)}));
          chk("R3", {tag, " data"}, got_data[s], exp_d[s]);
        end
      end
      chk("R2", {tag, " stray strobes"}, stray, 0);
      chk("R6", {tag, " no status write"}, sts_n, 0);
    end else begin
      chk(drop_perm ? "R7" : "R5", {tag, " no busy"}, busy_n, 0);
      chk(drop_perm ? "R7" : "R5", {tag, " no done"}, done_n, 0);
      for (int s = 0; s < 16; s++)
        if (got_we[s]) chk("R5", {tag, " no write"}, 1, 0);
      chk("R5", {tag, " stray"}, stray, 0);
    end
    if (inject) begin
      chk("R10", {tag, " idle after"}, busy, 0);
      chk("R10", {tag, " ready after"}, byte_ready, 0);
    end
  endtask

  task automatic run_status(int n, int bits, bit perm, string tag);
    logic [7:0] first = '0;
    bit c;
    open_session(9'h000, 1);
    if (!perm) wr_permit = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom());
      if (i == 0) first = d;
      send(d);
    end
    close(bits);
    wr_permit = 1;
    c = exp_commit(bits, 1, perm);
    repeat (PT + 6) @(negedge clk);
    if (c) begin
      chk("R6", {tag, " status strobes"}, sts_n, 1);
      chk("R6", {tag, " status cycle"}, sts_t, 0);
      chk("R6", {tag, " status data"}, sts_d, first);
      chk("R8", {tag, " busy length"}, busy_n, PT);
      chk("R9", {tag, " done"}, done_n, 1);
    end else begin
      chk(perm ? "R6" : "R7", {tag, " no status"}, sts_n, 0);
      chk(perm ? "R6" : "R7", {tag, " no busy"}, busy_n, 0);
    end
    for (int s = 0; s < 16; s++)
      if (got_we[s]) chk("R6", {tag, " no array write"}, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "arr_we", arr_we, 0);
    chk("R1", "sts_we", sts_we, 0);
    chk("R1", "ready", byte_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready after release", byte_ready, 0);

    run_array(9'h123, 1, 0, 0, 0, "single byte");
    run_array(9'h1FE, 5, 0, 0, 0, "cross slot15");
    run_array(9'h0A7, 20, 0, 0, 0, "wrap overwrite");
    run_array(9'h040, 16, 0, 0, 0, "full page");
    run_array(9'h055, 3, 1, 0, 0, "one bit late");
    run_array(9'h055, 3, -1, 0, 0, "one bit short");
    run_array(9'h010, 0, 0, 0, 0, "no data");
    run_array(9'h0F0, 4, 0, 1, 0, "permit drop");
    run_array(9'h19C, 6, 0, 0, 1, "busy inject");
    run_status(1, 16, 1, "status ok");
    run_status(2, 24, 1, "status 17th clock");
    run_status(1, 17, 1, "status 17 bits");
    run_status(1, 16, 0, "status no permit");

    for (int k = 0; k < 24; k++) begin
      int n = 1 + int'($urandom() % 36);
      int r = int'($urandom() % 10);
      int dl = (r < 7) ? 0 : (1 + int'($urandom() % 7)) * ((r == 9) ? -1 : 1);
      run_array(AW'($urandom()), n, dl, (r == 8), ($urandom() % 4 == 0), "random");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule